// File: doc/BRIEF.md
# Inbound Link Address Match and Remap

This block sits on the receive side of a serial link controller. It takes each incoming 64-bit link address and decides whether the transaction is for this device. To do that it compares the address with the base address registers (BARs), each under its own compare mask. If the address is accepted, the block rewrites it into a 32-bit internal bus address. The rewrite is driven by four programmable inbound windows. Each window names one BAR, a 64-bit start address and an internal base offset.

A mode input selects the number of BARs in use. In root-complex mode only BARs 0 and 1 are live. In endpoint mode all six are live. BAR0 is special: it always lands on the fixed application register base, so a host can reach the control registers with no software running locally. A global enable turns window translation on or off. The result is registered and appears one cycle after the request. It carries accept, reject, the BAR that hit, the window used, a flag for "no window names this BAR", and the internal address. All BAR, mask and window values arrive on configuration inputs that are held stable by the surrounding logic.

Top module: `ibx_inbound_map`

## Requirements
- R1: While reset is low, and in the first cycle after it, every output is zero.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high. When it is low, all other outputs are zero.
- R3: BAR n matches when `(addr XOR base_n) AND mask_n` is zero across all 64 bits. A mask bit of 1 means that bit is compared, so upper address bits count.
- R4: When `mode_rc_i` is 1, only BARs 0 and 1 can match. When it is 0, BARs 0 to 5 can match.
- R5: An address that matches no live BAR gives reject=1, accept=0, address 0, window 0, no-window flag 0 and BAR 0. An accepted address gives reject=0.
- R6: When several live BARs match, the lowest-numbered one is reported on `rsp_bar_o`.
- R7: A BAR0 hit gives the address 0x2180_0000 + (addr AND NOT mask_0)[31:0], window 0 and no-window flag 0. This holds whatever the windows or the enable say.
- R8: With translation on and a hit on BAR n>0, take the window whose 3-bit select field equals n. The output is (addr − start)[31:0] + offset, and the window number is reported. Example: BAR1 hits on 0xF740_1234, and the window has start 0xF740_0000 and offset 0x1080_0000. The output is 0x1080_1234.
- R9: When several windows select the same BAR, the lowest-numbered window is used.
- R10: With translation on, an accepted hit on BAR n>0 that no window selects sets the no-window flag. The output is addr[31:0], window 0.
- R11: With translation off, a hit on BAR n>0 gives addr[31:0], window 0 and no-window flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rc_i | input | 1 | 1 = root-complex mode (2 BARs live), 0 = endpoint mode (6 BARs live) |
| xlat_en_i | input | 1 | Global window translation enable |
| bar_base_i | input | 384 | Six 64-bit BAR bases; BAR n in bits [64n+63:64n] |
| bar_mask_i | input | 384 | Six 64-bit compare masks, same layout as the bases |
| win_sel_i | input | 12 | Four 3-bit BAR select fields; window w in bits [3w+2:3w] |
| win_start_i | input | 256 | Four 64-bit window start addresses |
| win_offset_i | input | 128 | Four 32-bit internal base offsets |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 64 | Incoming link address |
| rsp_valid_o | output | 1 | Result valid |
| rsp_accept_o | output | 1 | Address accepted |
| rsp_reject_o | output | 1 | Address rejected |
| rsp_no_win_o | output | 1 | Accepted, but no window names the BAR that hit |
| rsp_win_o | output | 2 | Window used |
| rsp_bar_o | output | 3 | BAR that hit |
| rsp_addr_o | output | 32 | Internal bus address |

## Verification
A wrong BAR priority, a wrong mask polarity or a stale mode decode would show up as a wrong `rsp_bar_o`. It could also flip accept and reject, and this would be visible on the very next cycle after the request. A wrong window choice or a broken subtraction would show as a wrong internal address and window number in that same result cycle. The bench therefore compares every output field on every clock against a behavioural model. It uses targeted overlaps (BARs that share ranges, windows that name the same BAR, high-word mismatches) plus randomised traffic with mode and enable changes.

// File: rtl/ibx_pkg.sv
// Package: shared constants for the inbound match/remap block.
// Assumes: a 32-bit internal bus and a fixed application register base.
package ibx_pkg;
    localparam logic [31:0] APP_REG_BASE = 32'h2180_0000;
    localparam int          LINK_AW      = 64;
    localparam int          INT_AW       = 32;
endpackage

// File: rtl/ibx_bar_match.sv
// Module: ibx_bar_match
// Compares the link address against each live BAR under its mask and
// reports the lowest-numbered hit. Assumes the configuration is stable.
module ibx_bar_match #(
    parameter int NUM_BARS = 6,
    parameter int RC_BARS  = 2,
    parameter int AW       = 64,
    parameter int IDX_W    = $clog2(NUM_BARS)
) (
    input  logic [AW-1:0]          addr_i,
    input  logic                   mode_rc_i,
    input  logic [NUM_BARS*AW-1:0] base_i,
    input  logic [NUM_BARS*AW-1:0] mask_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o
);
    logic [NUM_BARS-1:0] match;

    // One comparator per BAR, gated by whether the mode leaves it live.
    for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
        logic live;
        assign live     = mode_rc_i ? (b < RC_BARS) : 1'b1;
        assign match[b] = live &&
            (((addr_i ^ base_i[b*AW +: AW]) & mask_i[b*AW +: AW]) == '0);
    end

    // Priority pick: lowest-numbered matching BAR wins.
    always_comb begin
        hit_o = |match;
        idx_o = '0;
        for (int b = NUM_BARS - 1; b >= 0; b--) begin
            if (match[b]) idx_o = IDX_W'(b);
        end
    end
endmodule

// File: rtl/ibx_win_select.sv
// Module: ibx_win_select
// Finds the lowest-numbered window whose BAR select equals the hit BAR.
// Assumes select fields are as wide as a BAR index.
module ibx_win_select #(
    parameter int NUM_WINS = 4,
    parameter int SEL_W    = 3,
    parameter int WIDX_W   = $clog2(NUM_WINS)
) (
    input  logic [SEL_W-1:0]          bar_idx_i,
    input  logic [NUM_WINS*SEL_W-1:0] sel_i,
    output logic                      found_o,
    output logic [WIDX_W-1:0]         win_o
);
    logic [NUM_WINS-1:0] eq;

    // One equality compare per window.
    for (genvar w = 0; w < NUM_WINS; w++) begin : g_win
        assign eq[w] = (sel_i[w*SEL_W +: SEL_W] == bar_idx_i);
    end

    // Priority pick: lowest-numbered naming window wins.
    always_comb begin
        found_o = |eq;
        win_o   = '0;
        for (int w = NUM_WINS - 1; w >= 0; w--) begin
            if (eq[w]) win_o = WIDX_W'(w);
        end
    end
endmodule

// File: rtl/ibx_addr_remap.sv
// Module: ibx_addr_remap
// Forms the internal address from the hit BAR and window choice.
// Assumes hit_i qualifies all other inputs; output is don't-care otherwise.
module ibx_addr_remap #(
    parameter int          NUM_WINS = 4,
    parameter int          AW       = 64,
    parameter int          IAW      = 32,
    parameter int          SEL_W    = 3,
    parameter int          WIDX_W   = $clog2(NUM_WINS),
    parameter logic [31:0] APP_BASE = 32'h2180_0000
) (
    input  logic [AW-1:0]           addr_i,
    input  logic [SEL_W-1:0]        bar_idx_i,
    input  logic [AW-1:0]           mask0_i,
    input  logic                    xlat_en_i,
    input  logic                    found_i,
    input  logic [WIDX_W-1:0]       win_i,
    input  logic [NUM_WINS*AW-1:0]  start_i,
    input  logic [NUM_WINS*IAW-1:0] offset_i,
    output logic [IAW-1:0]          addr_o,
    output logic [WIDX_W-1:0]       win_o,
    output logic                    no_win_o
);
    logic [AW-1:0]  in_bar0;
    logic [AW-1:0]  delta;
    logic [AW-1:0]  win_start;
    logic [IAW-1:0] win_off;

    // Select the chosen window's start and offset; compute the offset in BAR0.
    always_comb begin
        win_start = start_i[win_i*AW +: AW];
        win_off   = offset_i[win_i*IAW +: IAW];
        in_bar0   = addr_i & ~mask0_i;
        delta     = addr_i - win_start;
    end

    // Choose the address source: BAR0 fixed, pass-through or windowed.
    always_comb begin
        addr_o   = addr_i[IAW-1:0];
        win_o    = '0;
        no_win_o = 1'b0;
        if (bar_idx_i == '0) begin
            addr_o = APP_BASE[IAW-1:0] + in_bar0[IAW-1:0];
        end else if (xlat_en_i) begin
            if (found_i) begin
                addr_o = delta[IAW-1:0] + win_off;
                win_o  = win_i;
            end else begin
                no_win_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ibx_inbound_map.sv
// Module: ibx_inbound_map (top)
// Accepts or rejects an inbound link address by BAR match and remaps it to
// the internal bus through four windows; result registered one cycle later.
// Assumes configuration inputs change only while no request is in flight.
module ibx_inbound_map #(
    parameter int NUM_BARS = 6,
    parameter int RC_BARS  = 2,
    parameter int NUM_WINS = 4,
    parameter int AW       = ibx_pkg::LINK_AW,
    parameter int IAW      = ibx_pkg::INT_AW,
    parameter int BIDX_W   = $clog2(NUM_BARS),
    parameter int WIDX_W   = $clog2(NUM_WINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_rc_i,
    input  logic                     xlat_en_i,
    input  logic [NUM_BARS*AW-1:0]   bar_base_i,
    input  logic [NUM_BARS*AW-1:0]   bar_mask_i,
    input  logic [NUM_WINS*BIDX_W-1:0] win_sel_i,
    input  logic [NUM_WINS*AW-1:0]   win_start_i,
    input  logic [NUM_WINS*IAW-1:0]  win_offset_i,
    input  logic                     req_valid_i,
    input  logic [AW-1:0]            req_addr_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_accept_o,
    output logic                     rsp_reject_o,
    output logic                     rsp_no_win_o,
    output logic [WIDX_W-1:0]        rsp_win_o,
    output logic [BIDX_W-1:0]        rsp_bar_o,
    output logic [IAW-1:0]           rsp_addr_o
);
    logic              bar_hit;
    logic [BIDX_W-1:0] bar_idx;
    logic              win_found;
    logic [WIDX_W-1:0] win_pick;
    logic [IAW-1:0]    map_addr;
    logic [WIDX_W-1:0] map_win;
    logic              map_no_win;

    ibx_bar_match #(
        .NUM_BARS(NUM_BARS), .RC_BARS(RC_BARS), .AW(AW), .IDX_W(BIDX_W)
    ) u_match (
        .addr_i   (req_addr_i),
        .mode_rc_i(mode_rc_i),
        .base_i   (bar_base_i),
        .mask_i   (bar_mask_i),
        .hit_o    (bar_hit),
        .idx_o    (bar_idx)
    );

    ibx_win_select #(
        .NUM_WINS(NUM_WINS), .SEL_W(BIDX_W), .WIDX_W(WIDX_W)
    ) u_wsel (
        .bar_idx_i(bar_idx),
        .sel_i    (win_sel_i),
        .found_o  (win_found),
        .win_o    (win_pick)
    );

    ibx_addr_remap #(
        .NUM_WINS(NUM_WINS), .AW(AW), .IAW(IAW), .SEL_W(BIDX_W),
        .WIDX_W(WIDX_W), .APP_BASE(ibx_pkg::APP_REG_BASE)
    ) u_remap (
        .addr_i   (req_addr_i),
        .bar_idx_i(bar_idx),
        .mask0_i  (bar_mask_i[AW-1:0]),
        .xlat_en_i(xlat_en_i),
        .found_i  (win_found),
        .win_i    (win_pick),
        .start_i  (win_start_i),
        .offset_i (win_offset_i),
        .addr_o   (map_addr),
        .win_o    (map_win),
        .no_win_o (map_no_win)
    );

    // Result register: qualified by valid and hit, cleared otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            rsp_accept_o <= 1'b0;
            rsp_reject_o <= 1'b0;
            rsp_no_win_o <= 1'b0;
            rsp_win_o    <= '0;
            rsp_bar_o    <= '0;
            rsp_addr_o   <= '0;
        end else begin
            rsp_valid_o  <= req_valid_i;
            rsp_accept_o <= req_valid_i && bar_hit;
            rsp_reject_o <= req_valid_i && !bar_hit;
            rsp_no_win_o <= req_valid_i && bar_hit && map_no_win;
            rsp_win_o    <= (req_valid_i && bar_hit) ? map_win  : '0;
            rsp_bar_o    <= (req_valid_i && bar_hit) ? bar_idx  : '0;
            rsp_addr_o   <= (req_valid_i && bar_hit) ? map_addr : '0;
        end
    end
endmodule

// File: rtl/ibx_checker.sv
// Module: ibx_checker
// Temporal properties on the ports of ibx_inbound_map; bound below.
module ibx_checker #(
    parameter int RC_BARS = 2,
    parameter int WIDX_W  = 2,
    parameter int BIDX_W  = 3,
    parameter int IAW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_rc_i,
    input logic              xlat_en_i,
    input logic              req_valid_i,
    input logic              rsp_valid_o,
    input logic              rsp_accept_o,
    input logic              rsp_reject_o,
    input logic              rsp_no_win_o,
    input logic [WIDX_W-1:0] rsp_win_o,
    input logic [BIDX_W-1:0] rsp_bar_o,
    input logic [IAW-1:0]    rsp_addr_o
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !rsp_accept_o && !rsp_reject_o));
    assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $countones({rsp_accept_o, rsp_reject_o}) == 1);
    assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reject_o |-> (rsp_addr_o == '0 && rsp_bar_o == '0 && !rsp_no_win_o));
    assert_rc_bars_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode_rc_i) |=> (!rsp_accept_o || rsp_bar_o < BIDX_W'(RC_BARS)));
    assert_bar0_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_accept_o && rsp_bar_o == '0) |-> (!rsp_no_win_o && rsp_win_o == '0));
    assert_off_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !xlat_en_i) |=> (!rsp_no_win_o && rsp_win_o == '0));
endmodule

bind ibx_inbound_map ibx_checker #(
    .RC_BARS(RC_BARS), .WIDX_W(WIDX_W), .BIDX_W(BIDX_W), .IAW(IAW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_rc_i(mode_rc_i), .xlat_en_i(xlat_en_i),
    .req_valid_i(req_valid_i), .rsp_valid_o(rsp_valid_o),
    .rsp_accept_o(rsp_accept_o), .rsp_reject_o(rsp_reject_o),
    .rsp_no_win_o(rsp_no_win_o), .rsp_win_o(rsp_win_o),
    .rsp_bar_o(rsp_bar_o), .rsp_addr_o(rsp_addr_o)
);

// File: tb/ibx_inbound_map_bench.sv
`timescale 1ns/1ps
module ibx_inbound_map_bench;
    typedef struct packed {
        logic        valid;
        logic        accept;
        logic        reject;
        logic        no_win;
        logic [1:0]  win;
        logic [2:0]  bar;
        logic [31:0] addr;
    } res_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_rc = 1'b0;
    logic         xlat_en = 1'b1;
    logic [383:0] bar_base = '0;
    logic [383:0] bar_mask = '0;
    logic [11:0]  win_sel = '0;
    logic [255:0] win_start = '0;
    logic [127:0] win_offset = '0;
    logic         req_valid = 1'b0;
    logic [63:0]  req_addr = '0;
    logic         rsp_valid, rsp_accept, rsp_reject, rsp_no_win;
    logic [1:0]   rsp_win;
    logic [2:0]   rsp_bar;
    logic [31:0]  rsp_addr;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    res_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    ibx_inbound_map u_ibx_inbound_map (
        .clk(clk), .rst_n(rst_n), .mode_rc_i(mode_rc), .xlat_en_i(xlat_en),
        .bar_base_i(bar_base), .bar_mask_i(bar_mask), .win_sel_i(win_sel),
        .win_start_i(win_start), .win_offset_i(win_offset),
        .req_valid_i(req_valid), .req_addr_i(req_addr),
        .rsp_valid_o(rsp_valid), .rsp_accept_o(rsp_accept),
        .rsp_reject_o(rsp_reject), .rsp_no_win_o(rsp_no_win),
        .rsp_win_o(rsp_win), .rsp_bar_o(rsp_bar), .rsp_addr_o(rsp_addr)
    );

    // Behavioural reference: what the requirements say the result must be.
    function automatic res_t model(input logic v, input logic [63:0] a);
        res_t r = '0;
        int hb = -1;
        logic [63:0] d;
        if (!v) return r;
        r.valid = 1'b1;
        for (int b = 0; b < 6; b++) begin
            logic [63:0] bs = bar_base[b*64 +: 64];
            logic [63:0] mk = bar_mask[b*64 +: 64];
            if (hb < 0 && (!mode_rc || b < 2) && ((a & mk) == (bs & mk))) hb = b;
        end
        if (hb < 0) begin
            r.reject = 1'b1;
            return r;
        end
        r.accept = 1'b1;
        r.bar = 3'(hb);
        if (hb == 0) begin
            d = a & ~bar_mask[63:0];
            r.addr = 32'h2180_0000 + d[31:0];
        end else if (!xlat_en) begin
            r.addr = a[31:0];
        end else begin
            int hw = -1;
            for (int w = 0; w < 4; w++)
                if (hw < 0 && int'(win_sel[w*3 +: 3]) == hb) hw = w;
            if (hw < 0) begin
                r.no_win = 1'b1;
                r.addr = a[31:0];
            end else begin
                d = a - win_start[hw*64 +: 64];
                r.addr = d[31:0] + win_offset[hw*32 +: 32];
                r.win = 2'(hw);
            end
        end
        return r;
    endfunction

    function automatic res_t observed();
        return {rsp_valid, rsp_accept, rsp_reject, rsp_no_win, rsp_win, rsp_bar, rsp_addr};
    endfunction

    task automatic check(input res_t exp, input string tag);
        res_t got = observed();
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock: check last result, then drive the next request.
    task automatic step(input logic v, input logic [63:0] a, input string tag);
        @(negedge clk);
        check(exp_q.pop_front(), tag_q.pop_front());
        req_valid = v;
        req_addr  = a;
        exp_q.push_back(model(v, a));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        step(1'b0, 64'h0, "R2 idle");
    endtask

    task automatic set_bar(input int b, input logic [63:0] bs, input logic [63:0] mk);
        bar_base[b*64 +: 64] = bs;
        bar_mask[b*64 +: 64] = mk;
    endtask

    task automatic set_win(input int w, input logic [2:0] s, input logic [63:0] st,
                           input logic [31:0] off);
        win_sel[w*3 +: 3] = s;
        win_start[w*64 +: 64] = st;
        win_offset[w*32 +: 32] = off;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        set_bar(0, 64'h0000_0000_E000_0000, 64'hFFFF_FFFF_FFFF_0000);
        set_bar(1, 64'h0000_0000_F740_0000, 64'hFFFF_FFFF_FFF0_0000);
        set_bar(2, 64'h0000_0000_A000_0000, 64'hFFFF_FFFF_FFF0_0000);
        set_bar(3, 64'h0000_0000_B000_0000, 64'hFFFF_FFFF_F000_0000);
        set_bar(4, 64'h0000_0000_B100_0000, 64'hFFFF_FFFF_FF00_0000);
        set_bar(5, 64'h0000_0012_3400_0000, 64'hFFFF_FFFF_FFF0_0000);
        set_win(0, 3'd1, 64'h0000_0000_F740_0000, 32'h1080_0000);
        set_win(1, 3'd3, 64'h0000_0000_B000_0000, 32'h0C00_0000);
        set_win(2, 3'd3, 64'h0000_0000_B000_0000, 32'h0D00_0000);
        set_win(3, 3'd5, 64'h0000_0012_3400_0000, 32'h0080_0000);

        // R1: outputs zero while reset is held, even with a request driven.
        req_valid = 1'b1;
        req_addr  = 64'hF740_1234;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check('0, "R1 reset");
        end
        req_valid = 1'b0;
        rst_n = 1'b1;
        exp_q.push_back('0);
        tag_q.push_back("R1 after reset");

        // Root-complex mode.
        idle();
        mode_rc = 1'b1;
        step(1, 64'h0000_0000_F740_1234, "R8 example maps to 0x1080_1234");
        step(1, 64'h0000_0000_E000_0ABC, "R7 BAR0 to app base");
        step(1, 64'h0000_0000_A000_0010, "R4 BAR2 dead in RC mode");
        step(1, 64'h0000_0012_3400_0040, "R4 BAR5 dead in RC mode");
        step(1, 64'h0000_0001_F740_1234, "R3 high word compared");
        step(1, 64'h0000_0000_F750_0000, "R5 just past BAR1");
        idle();

        // Endpoint mode.
        mode_rc = 1'b0;
        step(1, 64'h0000_0000_A000_0010, "R4 BAR2 live in EP; R10 no window");
        step(1, 64'h0000_0000_B100_0040, "R6 BAR3 beats BAR4; R9 window1 beats window2");
        step(1, 64'h0000_0000_B000_0004, "R9 lowest window");
        step(1, 64'h0000_0012_3400_5678, "R8 64-bit start");
        step(1, 64'h0000_0000_1234_5678, "R5 no BAR");
        idle();

        // Region naming BAR0 and translation off must not disturb BAR0.
        set_win(0, 3'd0, 64'h0000_0000_E000_0000, 32'h5555_0000);
        idle();
        step(1, 64'h0000_0000_E000_FFFC, "R7 window names BAR0 ignored");
        step(1, 64'h0000_0000_F740_1234, "R10 BAR1 now without window");
        idle();
        xlat_en = 1'b0;
        idle();
        step(1, 64'h0000_0000_E000_0010, "R7 BAR0 with translation off");
        step(1, 64'h0000_0000_F740_1234, "R11 pass-through when off");
        step(1, 64'h0000_0000_B000_0020, "R11 pass-through BAR3");
        idle();
        xlat_en = 1'b1;
        set_win(0, 3'd1, 64'h0000_0000_F740_0000, 32'h1080_0000);
        idle();

        // Randomised traffic with occasional mode/enable changes.
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a;
            int b = int'($urandom_range(0, 6));
            if (i % 40 == 39) begin
                idle();
                mode_rc = $urandom_range(0, 1) == 1;
                xlat_en = $urandom_range(0, 3) != 0;
                idle();
            end
            if (b == 6) a = {$urandom, $urandom};
            else a = bar_base[b*64 +: 64] | {44'h0, 20'($urandom)};
            step($urandom_range(0, 4) != 0, a, "R3 R6 R8 random traffic");
        end
        idle();
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule